// File: doc/BRIEF.md
# Header Lock and Multiblock Aligner

This block sits on the receive side of a 64b/66b serial converter link, directly after the gearbox. The gearbox delivers one 66-bit candidate block at a time. Bits 65:64 form the two-bit header and bits 63:0 carry the payload. Every block whose two header bits are equal is a misaligned candidate. While the block is hunting, each such block produces a one-cycle slip request that tells the gearbox to shift its boundary by one bit. A long run of good headers declares header lock.

With header lock held, the first header bit of each block (bit 65) feeds a serial sync word, one bit per block. A multiblock is 32 blocks, and a pilot pattern 0,0,0,0,1 closes each multiblock in blocks 27 to 31. The transmitter also sets a marker bit at a fixed block position. The marker is 1 only in the last multiblock of an extended multiblock and 0 in the others. The aligner locks onto the pilot, predicts where each extended multiblock ends, and declares extended-multiblock lock once the predictions hold. While that lock is held, it presents the payload with its block and multiblock position. No comma characters and no request pin are involved.

Top module: `sh_mb_aligner`

## Requirements
- R1: After reset, shLock, embLock, slipReq and payValid are all 0.
- R2: While shLock is 0, every accepted block (blkValid=1) whose header bits 65 and 64 are equal (00 or 11) gives a one-cycle pulse on slipReq in the next cycle. No other condition raises slipReq.
- R3: shLock rises after 64 consecutive accepted blocks with unequal header bits. An invalid header in the run restarts the count. Idle cycles (blkValid=0) neither count nor break the run.
- R4: While shLock is 1, fewer than 16 invalid headers inside one 64-block window keep the lock.
- R5: While shLock is 1, the 16th invalid header inside one 64-block window clears shLock. It also clears embLock.
- R6: The sync bit of a block is its header bit 65. A multiblock ends at the block that completes the bit sequence 0,0,0,0,1. The marker is the sync bit of block MARK_POS (default 2), and it is 1 only in multiblock EMB_LEN-1 (default 3). embLock rises at the end of the second extended multiblock whose end was correctly predicted after the marker first anchored the count. embLock is never 1 while shLock is 0.
- R7: While embLock is 1, up to 3 consecutive multiblocks with a missing pilot or a wrong marker value keep embLock. A correct multiblock clears the miss count.
- R8: The 4th consecutive bad multiblock clears embLock at the end of that multiblock.
- R9: While embLock is 1, each accepted block appears one cycle later on payData with payValid=1, blkPos (its index in the multiblock, 0 to 31) and mbPos (its index in the extended multiblock). While embLock is 0, payValid stays 0.
- R10: While shLock is 1 and embLock is 0, a pilot that completes anywhere other than block 31 realigns the index, so the next block is block 0 of multiblock 0. While embLock is 1, a pilot seen elsewhere is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blkValid | input | 1 | A candidate block is present this cycle |
| blkData | input | 66 | Header in bits 65:64, payload in bits 63:0 |
| slipReq | output | 1 | Shift the block boundary by one bit |
| shLock | output | 1 | Header lock |
| embLock | output | 1 | Extended multiblock lock |
| payValid | output | 1 | payData, blkPos and mbPos hold an aligned block |
| payData | output | 64 | Payload of the aligned block |
| blkPos | output | 5 | Block index inside the multiblock |
| mbPos | output | 2 | Multiblock index inside the extended multiblock |

## Verification
On every cycle, the assertions check the lock ordering: extended lock only under header lock, and slip requests only while hunting. They also check that header lock only rises on a valid header, that the invalid-header count stays below its limit, and that extended lock only falls at a multiblock end while header lock holds. The counting thresholds can only be shown by the bench's scenarios and its cycle-level model. These are the 63 versus 64 good headers, the 15 versus 16 errors per window, and 3 versus 4 bad multiblocks. The scenarios also show the anchoring and two-period confirmation of the extended multiblock, realignment to a pilot that arrives mid-count, and the position labels on delivered payload.

// File: rtl/sh_mb_aligner_pkg.sv
package sh_mb_aligner_pkg;

  // Strobes from the lock control to the datapath
  typedef struct packed {
    logic clrPos;    // hold block and multiblock index at zero
    logic realign;   // pilot seen mid-count: restart the index
    logic anchor;    // marker seen: restart the multiblock count
    logic passData;  // extended lock held: deliver payload
  } alnStrobe_t;

  localparam logic [4:0] PILOT_SEQ = 5'b00001;

endpackage

// File: rtl/sh_mb_aligner_dp.sv
module sh_mb_aligner_dp
  import sh_mb_aligner_pkg::*;
#(
  parameter int MB_LEN   = 32,
  parameter int EMB_LEN  = 4,
  parameter int MARK_POS = 2,
  parameter int PAY_W    = 64,
  parameter int BLK_W    = $clog2(MB_LEN),
  parameter int MB_W     = (EMB_LEN > 1) ? $clog2(EMB_LEN) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             blkValid,
  input  logic [PAY_W+1:0] blkData,
  input  alnStrobe_t       strobe,
  output logic             hdrOk,
  output logic             pilotHit,
  output logic             atMbEnd,
  output logic             atEmbEnd,
  output logic             markBit,
  output logic             payValid,
  output logic [PAY_W-1:0] payData,
  output logic [BLK_W-1:0] blkPos,
  output logic [MB_W-1:0]  mbPos
);

  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(MB_LEN - 1);
  localparam logic [BLK_W-1:0] BLK_MARK = BLK_W'(MARK_POS);
  localparam logic [MB_W-1:0]  MB_LAST  = MB_W'(EMB_LEN - 1);

  logic             hdrBit;
  logic [3:0]       hist;
  logic [BLK_W-1:0] blkIdx;
  logic [MB_W-1:0]  mbIdx;
  logic             markReg;

  assign hdrBit   = blkData[PAY_W+1];
  assign hdrOk    = blkData[PAY_W+1] ^ blkData[PAY_W];
  assign pilotHit = blkValid && ({hist, hdrBit} == PILOT_SEQ);
  assign atMbEnd  = (blkIdx == BLK_LAST);
  assign atEmbEnd = (mbIdx == MB_LAST);
  assign markBit  = markReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist    <= 4'hF;
      markReg <= 1'b0;
    end else if (blkValid) begin
      hist <= {hist[2:0], hdrBit};
      if (blkIdx == BLK_MARK) markReg <= hdrBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkIdx <= '0;
      mbIdx  <= '0;
    end else if (strobe.clrPos || strobe.realign) begin
      blkIdx <= '0;
      mbIdx  <= '0;
    end else if (blkValid) begin
      blkIdx <= atMbEnd ? '0 : blkIdx + BLK_W'(1);
      if (atMbEnd) mbIdx <= (strobe.anchor || atEmbEnd) ? '0 : mbIdx + MB_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      payValid <= 1'b0;
      payData  <= '0;
      blkPos   <= '0;
      mbPos    <= '0;
    end else begin
      payValid <= blkValid && strobe.passData;
      if (blkValid) begin
        payData <= blkData[PAY_W-1:0];
        blkPos  <= blkIdx;
        mbPos   <= mbIdx;
      end
    end
  end

endmodule

// File: rtl/sh_mb_aligner_ctrl.sv
module sh_mb_aligner_ctrl
  import sh_mb_aligner_pkg::*;
#(
  parameter int SH_LOCK_CNT = 64,
  parameter int WIN_LEN     = 64,
  parameter int BAD_LIMIT   = 16,
  parameter int EMB_GOOD    = 2,
  parameter int EMB_MISS    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       blkValid,
  input  logic       hdrOk,
  input  logic       pilotHit,
  input  logic       atMbEnd,
  input  logic       atEmbEnd,
  input  logic       markBit,
  output logic       slipReq,
  output logic       shLock,
  output logic       embLock,
  output alnStrobe_t strobe
);

  localparam int SG_W = $clog2(SH_LOCK_CNT);
  localparam int WN_W = $clog2(WIN_LEN);
  localparam int BD_W = $clog2(BAD_LIMIT + 1);
  localparam int GD_W = $clog2(EMB_GOOD + 1);
  localparam int MS_W = $clog2(EMB_MISS + 1);

  logic [SG_W-1:0] shGood;
  logic [WN_W-1:0] winCnt;
  logic [BD_W-1:0] badCnt, badNext;
  logic [GD_W-1:0] goodCnt, goodNext;
  logic [MS_W-1:0] missCnt, missNext;
  logic            anchored;
  logic            dropSh, hunting, mbOk;

  assign badNext  = badCnt + BD_W'(!hdrOk);
  assign goodNext = goodCnt + GD_W'(1);
  assign missNext = missCnt + MS_W'(1);
  assign dropSh   = shLock && blkValid && (badNext == BD_W'(BAD_LIMIT));
  assign hunting  = shLock && !dropSh && !embLock && blkValid;
  assign mbOk     = pilotHit && (markBit == atEmbEnd);

  always_comb begin
    strobe          = '0;
    strobe.clrPos   = !shLock || dropSh;
    strobe.realign  = hunting && pilotHit && !atMbEnd;
    strobe.anchor   = hunting && atMbEnd && pilotHit && markBit && !(anchored && atEmbEnd);
    strobe.passData = embLock;
  end

  // Header lock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shLock  <= 1'b0;
      slipReq <= 1'b0;
      shGood  <= '0;
      winCnt  <= '0;
      badCnt  <= '0;
    end else begin
      slipReq <= 1'b0;
      if (blkValid) begin
        if (!shLock) begin
          if (!hdrOk) begin
            slipReq <= 1'b1;
            shGood  <= '0;
          end else if (shGood == SG_W'(SH_LOCK_CNT - 1)) begin
            shLock <= 1'b1;
            shGood <= '0;
            winCnt <= '0;
            badCnt <= '0;
          end else begin
            shGood <= shGood + SG_W'(1);
          end
        end else if (dropSh) begin
          shLock <= 1'b0;
          shGood <= '0;
        end else if (winCnt == WN_W'(WIN_LEN - 1)) begin
          winCnt <= '0;
          badCnt <= '0;
        end else begin
          winCnt <= winCnt + WN_W'(1);
          badCnt <= badNext;
        end
      end
    end
  end

  // Extended multiblock lock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      embLock  <= 1'b0;
      anchored <= 1'b0;
      goodCnt  <= '0;
      missCnt  <= '0;
    end else if (strobe.clrPos) begin
      embLock  <= 1'b0;
      anchored <= 1'b0;
      goodCnt  <= '0;
      missCnt  <= '0;
    end else if (blkValid) begin
      if (embLock) begin
        if (atMbEnd) begin
          if (mbOk) begin
            missCnt <= '0;
          end else if (missNext == MS_W'(EMB_MISS)) begin
            embLock  <= 1'b0;
            anchored <= 1'b0;
            goodCnt  <= '0;
            missCnt  <= '0;
          end else begin
            missCnt <= missNext;
          end
        end
      end else if (strobe.realign) begin
        anchored <= 1'b0;
        goodCnt  <= '0;
      end else if (atMbEnd) begin
        if (!pilotHit) begin
          anchored <= 1'b0;
          goodCnt  <= '0;
        end else if (markBit) begin
          if (anchored && atEmbEnd) begin
            if (goodNext == GD_W'(EMB_GOOD)) begin
              embLock <= 1'b1;
              goodCnt <= '0;
              missCnt <= '0;
            end else begin
              goodCnt <= goodNext;
            end
          end else begin
            anchored <= 1'b1;
            goodCnt  <= '0;
          end
        end else if (anchored && atEmbEnd) begin
          anchored <= 1'b0;
          goodCnt  <= '0;
        end
      end
    end
  end

  a_r6_emb_needs_sh: assert property (@(posedge clk) disable iff (!rstN)
    embLock |-> shLock);
  a_r2_slip_only_hunting: assert property (@(posedge clk) disable iff (!rstN)
    slipReq |-> !shLock);
  a_r3_lock_on_good_hdr: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shLock) |-> $past(blkValid && hdrOk));
  a_r5_bad_below_limit: assert property (@(posedge clk) disable iff (!rstN)
    badCnt < BD_W'(BAD_LIMIT));
  a_r8_emb_falls_at_mb_end: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(embLock) && shLock) |-> $past(blkValid && atMbEnd));

endmodule

// File: rtl/sh_mb_aligner.sv
module sh_mb_aligner
  import sh_mb_aligner_pkg::*;
#(
  parameter int MB_LEN      = 32,
  parameter int EMB_LEN     = 4,
  parameter int MARK_POS    = 2,
  parameter int SH_LOCK_CNT = 64,
  parameter int WIN_LEN     = 64,
  parameter int BAD_LIMIT   = 16,
  parameter int EMB_GOOD    = 2,
  parameter int EMB_MISS    = 4,
  parameter int PAY_W       = 64,
  parameter int BLK_W       = $clog2(MB_LEN),
  parameter int MB_W        = (EMB_LEN > 1) ? $clog2(EMB_LEN) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             blkValid,
  input  logic [PAY_W+1:0] blkData,
  output logic             slipReq,
  output logic             shLock,
  output logic             embLock,
  output logic             payValid,
  output logic [PAY_W-1:0] payData,
  output logic [BLK_W-1:0] blkPos,
  output logic [MB_W-1:0]  mbPos
);

  alnStrobe_t strobe;
  logic hdrOk, pilotHit, atMbEnd, atEmbEnd, markBit;

  sh_mb_aligner_ctrl #(
    .SH_LOCK_CNT(SH_LOCK_CNT), .WIN_LEN(WIN_LEN), .BAD_LIMIT(BAD_LIMIT),
    .EMB_GOOD(EMB_GOOD), .EMB_MISS(EMB_MISS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .blkValid(blkValid), .hdrOk(hdrOk),
    .pilotHit(pilotHit), .atMbEnd(atMbEnd), .atEmbEnd(atEmbEnd),
    .markBit(markBit), .slipReq(slipReq), .shLock(shLock),
    .embLock(embLock), .strobe(strobe)
  );

  sh_mb_aligner_dp #(
    .MB_LEN(MB_LEN), .EMB_LEN(EMB_LEN), .MARK_POS(MARK_POS),
    .PAY_W(PAY_W), .BLK_W(BLK_W), .MB_W(MB_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .blkValid(blkValid), .blkData(blkData),
    .strobe(strobe), .hdrOk(hdrOk), .pilotHit(pilotHit),
    .atMbEnd(atMbEnd), .atEmbEnd(atEmbEnd), .markBit(markBit),
    .payValid(payValid), .payData(payData), .blkPos(blkPos), .mbPos(mbPos)
  );

endmodule

// File: tb/test_sh_mb_aligner.sv
module test_sh_mb_aligner;

  localparam int CLK_PERIOD = 10;
  localparam int MARK_AT = 2;
  localparam int EMB_N   = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        blkValid = 1'b0;
  logic [65:0] blkData = '0;
  logic        slipReq, shLock, embLock, payValid;
  logic [63:0] payData;
  logic [4:0]  blkPos;
  logic [1:0]  mbPos;

  sh_mb_aligner i_sh_mb_aligner (
    .clk(clk), .rstN(rstN), .blkValid(blkValid), .blkData(blkData),
    .slipReq(slipReq), .shLock(shLock), .embLock(embLock),
    .payValid(payValid), .payData(payData), .blkPos(blkPos), .mbPos(mbPos)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFails = 0, slipSeen = 0, cycles = 0;
  bit done = 0;

  // behavioural reference state
  bit mSh, mEmb, mSlip, mPv, mAnch, mMark;
  bit [63:0] mPay;
  int mPb, mPm, mGood, mWin, mBad, mGd, mMiss, mBlk, mMb;
  bit hq[$];

  // transmitter position
  int txBlk = 0, txMb = 0, lastBlk, lastMb, sent = 0;
  bit [63:0] lastPay;

  task automatic check(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelStep(bit v, bit [65:0] d);
    bit hv, b, pil, drop, endMb, embEnd, oldSh, oldEmb, oldMark;
    int oldBlk, oldMb, nb, nBlk, nMb;
    oldSh = mSh; oldEmb = mEmb; oldBlk = mBlk; oldMb = mMb; oldMark = mMark;
    mSlip = 0;
    mPv = v && oldEmb;
    if (!v) return;
    hv = d[65] ^ d[64];
    b = d[65];
    pil = (hq[0] == 0) && (hq[1] == 0) && (hq[2] == 0) && (hq[3] == 0) && b;
    void'(hq.pop_front());
    hq.push_back(b);
    mPay = d[63:0]; mPb = oldBlk; mPm = oldMb;
    drop = 0;
    if (!oldSh) begin
      if (!hv) begin mSlip = 1; mGood = 0; end
      else if (mGood == 63) begin mSh = 1; mGood = 0; mWin = 0; mBad = 0; end
      else mGood++;
    end else begin
      nb = mBad + (hv ? 0 : 1);
      if (nb == 16) begin drop = 1; mSh = 0; mGood = 0; end
      else if (mWin == 63) begin mWin = 0; mBad = 0; end
      else begin mWin++; mBad = nb; end
    end
    if (oldBlk == MARK_AT) mMark = b;
    endMb = (oldBlk == 31);
    embEnd = (oldMb == EMB_N - 1);
    if (!oldSh || drop) begin
      mEmb = 0; mAnch = 0; mGd = 0; mMiss = 0; mBlk = 0; mMb = 0;
    end else begin
      nBlk = endMb ? 0 : oldBlk + 1;
      nMb = endMb ? (embEnd ? 0 : oldMb + 1) : oldMb;
      if (oldEmb) begin
        if (endMb) begin
          if (pil && (oldMark == embEnd)) mMiss = 0;
          else if (mMiss + 1 == 4) begin mEmb = 0; mAnch = 0; mGd = 0; mMiss = 0; end
          else mMiss++;
        end
      end else if (pil && !endMb) begin
        nBlk = 0; nMb = 0; mAnch = 0; mGd = 0;
      end else if (endMb) begin
        if (!pil) begin mAnch = 0; mGd = 0; end
        else if (oldMark) begin
          if (mAnch && embEnd) begin
            if (mGd + 1 == 2) begin mEmb = 1; mGd = 0; mMiss = 0; end
            else mGd++;
          end else begin mAnch = 1; mGd = 0; nMb = 0; end
        end else if (mAnch && embEnd) begin mAnch = 0; mGd = 0; end
      end
      mBlk = nBlk; mMb = nMb;
    end
  endtask

  task automatic step(bit v, bit [65:0] d);
    @(negedge clk);
    check("R5 shLock", shLock, mSh);
    check("R6 embLock", embLock, mEmb);
    check("R2 slipReq", slipReq, mSlip);
    check("R9 payValid", payValid, mPv);
    if (mPv) begin
      check("R9 payData", payData, mPay);
      check("R10 blkPos", blkPos, mPb);
      check("R9 mbPos", mbPos, mPm);
    end
    if (slipReq) slipSeen++;
    blkValid = v;
    blkData = d;
    modelStep(v, d);
  endtask

  // bad: send header 11; flip: invert the marker bit
  task automatic sendTx(int n, bit bad, bit flip);
    for (int i = 0; i < n; i++) begin
      bit sb;
      bit [63:0] p;
      sb = (txBlk == 31) ? 1'b1 :
           (txBlk == MARK_AT) ? (txMb == EMB_N - 1) : 1'b0;
      if (flip && txBlk == MARK_AT) sb = ~sb;
      p = {$urandom(), $urandom()};
      step(1'b1, {bad ? 2'b11 : {sb, ~sb}, p});
      lastBlk = txBlk; lastMb = txMb; lastPay = p;
      txBlk = (txBlk + 1) % 32;
      if (txBlk == 0) txMb = (txMb + 1) % EMB_N;
      sent++;
      if (sent % 5 == 0) step(1'b0, '0);
    end
  endtask

  task automatic toBoundary();
    while (txBlk != 0) sendTx(1, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) hq.push_back(1'b1);
    txBlk = 9; txMb = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 shLock", shLock, 0);
    check("R1 embLock", embLock, 0);
    check("R1 slipReq", slipReq, 0);
    check("R1 payValid", payValid, 0);
    rstN = 1'b1;
    // R2: five invalid headers give five slips
    sendTx(5, 1, 0);
    step(0, '0);
    step(0, '0);
    check("R2 slip count", slipSeen, 5);
    // R3: 63 good headers are not enough, an invalid one restarts
    sendTx(63, 0, 0); step(0, '0);
    check("R3 no lock at 63", shLock, 0);
    sendTx(1, 1, 0); sendTx(63, 0, 0); step(0, '0);
    check("R3 restart after bad", shLock, 0);
    sendTx(1, 0, 0); step(0, '0);
    check("R3 lock at 64", shLock, 1);
    // R6: one extended period is not enough, three are
    sendTx(128, 0, 0); step(0, '0);
    check("R6 not yet locked", embLock, 0);
    sendTx(256, 0, 0); step(0, '0);
    check("R6 emb locked", embLock, 1);
    // R9 / R10: positions follow the transmitter after realignment
    sendTx(1, 0, 0); step(0, '0);
    check("R9 payValid", payValid, 1);
    check("R9 payData", payData, lastPay);
    check("R10 blkPos", blkPos, lastBlk);
    check("R9 mbPos", mbPos, lastMb);
    // R4: 15 errors keep header lock, R7 keeps emb lock
    sendTx(15, 1, 0); sendTx(64, 0, 0); step(0, '0);
    check("R4 sh kept", shLock, 1);
    check("R7 emb kept", embLock, 1);
    // R5: a long burst drops both locks
    sendTx(40, 1, 0); step(0, '0);
    check("R5 sh dropped", shLock, 0);
    check("R5 emb dropped", embLock, 0);
    // relock
    sendTx(64 + 3 * 128 + 64, 0, 0); step(0, '0);
    check("R6 relocked", embLock, 1);
    // R7: three bad multiblocks are tolerated
    toBoundary();
    sendTx(96, 0, 1); step(0, '0);
    check("R7 three misses", embLock, 1);
    sendTx(64, 0, 0);
    // R8: four bad multiblocks drop emb lock
    toBoundary();
    sendTx(96, 0, 1); step(0, '0);
    check("R8 still locked at 3", embLock, 1);
    sendTx(32, 0, 1); step(0, '0);
    check("R8 dropped at 4", embLock, 0);
    check("R8 sh kept", shLock, 1);
    sendTx(40, 0, 0);
    step(0, '0); step(0, '0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nChecks++;
        nFails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
        $finish;
      end
    end
  end

endmodule